// File: doc/BRIEF.md
# Serial Byte-Memory Slave on a Two-Wire Bus

This block is a two-wire bus slave in front of a byte-wide memory held in registers. It runs on the system clock. It samples the bus clock and data lines through synchronising flops and finds START, repeated START and STOP from the edges it sees. It does not drive the bus clock. It pulls the data line low through `sda_oe`, so a high level on that output means "pull low".

A master first sends a select byte, then a two-byte memory address, then data. It can write single bytes or a run of bytes within a 32-byte page. It can read from the address left behind by the last access, or set an address with a dummy write and then read after a repeated START. Reads continue through the array for as long as the master acknowledges each byte.

A write-control input protects the upper quarter of the array. Its level is gathered from START until the second address byte has been taken.

Top module: `i2c_ee_slave`

## Requirements
- R1: After reset `sda_oe` is 0. The slave releases the data line at all times except when it acknowledges or sends a 0 data bit.
- R2: The first byte after a START is taken MSB first. Bits 7:4 must be 1010, bits 3:1 must equal `chip_sel[2:0]`, and bit 0 selects a read (1) or a write (0). On a match the slave pulls the data line low during the 9th clock, and it never pulls low for an acknowledge outside a 9th clock.
- R3: If the select byte does not match, the slave does not acknowledge it. It then leaves the line released for all further bytes until the next START.
- R4: A write takes two address bytes, high byte first, then data bytes. The slave acknowledges each of these bytes and stores each data byte at the current address.
- R5: Address bits at and above `ADDR_W` (12 by default, for a 4096-byte array) are ignored.
- R6: A random read is a write of the select byte and two address bytes, then a repeated START and a select byte with bit 0 = 1. It returns the byte at that address, MSB first, and the slave changes the data line only while SCL is low.
- R7: A page write stores up to 32 data bytes at consecutive addresses.
- R8: During a write, only the low 5 address bits advance and they wrap. Bytes past the end of a 32-byte page overwrite that page from its start, and the upper address bits never change.
- R9: During a read the address advances by one after each byte and wraps from the last array location to 0. The slave never drives the line during the master's acknowledge bit.
- R10: A master NACK followed by STOP ends a read. A later read with no address phase returns the byte after the last byte sent.
- R11: If `wr_ctl` is high at any time from START until the end of the second address byte, data bytes aimed at addresses whose two top bits are 11 leave the memory unchanged. They are still acknowledged, and writes below that quarter still take effect.
- R12: `wr_ctl` high only during the data bytes has no effect on a write.
- R13: `sda_oe` holds steady while SCL stays high, except at START and STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 = pull the data line low |
| chip_sel | input | 3 | Strap value compared with select byte bits 3:1 |
| wr_ctl | input | 1 | Write control for the upper quarter of the array |

## Verification
The checker watches several rules on every cycle. The line stays released while the slave is deselected. Acknowledge drive appears only in a 9th bit slot. The slave stays off the line during the master's acknowledge in a read. The output holds steady through a settled SCL high. No memory write reaches the protected quarter inside the write-control window, and a write never moves the upper address bits. Stored and returned byte values, page wrap, array wrap, address continuity across transactions and the ignored upper address bits depend on whole bus sequences. Only the bench's scenarios can show these, by comparing each byte it reads with its own memory model.

// File: rtl/i2c_ee_pkg.sv
package i2c_ee_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_DEV  = 3'd1,
    ST_AHI  = 3'd2,
    ST_ALO  = 3'd3,
    ST_WR   = 3'd4,
    ST_RD   = 3'd5
  } ee_st_e;

  localparam logic [3:0] DEV_TYPE = 4'b1010;
  localparam logic [3:0] CNT_ACK  = 4'd8;
  localparam logic [3:0] CNT_PRE  = 4'd15;
endpackage

// File: rtl/i2c_ee_linesync.sv
module i2c_ee_linesync #(
  parameter int SYNC_N = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic [SYNC_N-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q, scl_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[SYNC_N-2:0], scl_i};
      sda_ff <= {sda_ff[SYNC_N-2:0], sda_i};
      scl_q  <= scl_s;
      sda_q  <= sda_s;
    end
  end

  assign scl_s     = scl_ff[SYNC_N-1];
  assign sda_s     = sda_ff[SYNC_N-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_ee_mem.sv
module i2c_ee_mem #(
  parameter int AW = 12,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[addr] <= wdata;
  end

  assign rdata = cells[addr];
endmodule

// File: rtl/i2c_ee_slave.sv
module i2c_ee_slave
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_oe,
  input  logic [2:0] chip_sel,
  input  logic       wr_ctl
);
  localparam int HI_W = ADDR_W - 8;
  localparam logic [PAGE_W-1:0] PG_ONE   = PAGE_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  ee_st_e st_q, st_d;
  logic [3:0] cnt_q, cnt_d;
  logic [7:0] rx_q, rx_d, tx_q, tx_d, mem_rdata;
  logic [HI_W-1:0] ahi_q, ahi_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic rw_q, rw_d, ack_q, ack_d, mack_q, mack_d, wp_q, wp_d;
  logic mem_we, top_hit;

  i2c_ee_linesync #(.SYNC_N(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det)
  );

  i2c_ee_mem #(.AW(ADDR_W), .DW(8)) u_mem (
    .clk(clk), .we(mem_we), .addr(addr_q), .wdata(rx_q), .rdata(mem_rdata)
  );

  assign top_hit = (addr_q[ADDR_W-1 -: 2] == 2'b11);

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    rx_d   = rx_q;
    tx_d   = tx_q;
    ahi_d  = ahi_q;
    addr_d = addr_q;
    rw_d   = rw_q;
    ack_d  = ack_q;
    mack_d = mack_q;
    wp_d   = wp_q;
    mem_we = 1'b0;
    if (start_det) begin
      st_d  = ST_DEV;
      cnt_d = CNT_PRE;
      ack_d = 1'b0;
      wp_d  = wr_ctl;
    end else if (stop_det) begin
      st_d  = ST_IDLE;
      cnt_d = CNT_PRE;
      ack_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (st_q == ST_DEV || st_q == ST_AHI || st_q == ST_ALO) wp_d = wp_q | wr_ctl;
      if (scl_rise) begin
        if (cnt_q < CNT_ACK) rx_d = {rx_q[6:0], sda_s};
        else if (cnt_q == CNT_ACK) mack_d = ~sda_s;
      end
      if (scl_fall) begin
        if (cnt_q == CNT_PRE) begin
          cnt_d = 4'd0;
        end else if (cnt_q < CNT_ACK) begin
          cnt_d = cnt_q + 4'd1;
          if (st_q == ST_RD) tx_d = {tx_q[6:0], 1'b0};
          if (cnt_q == 4'd7 && st_q != ST_RD) begin
            unique case (st_q)
              ST_DEV: begin
                if (rx_q[7:4] == DEV_TYPE && rx_q[3:1] == chip_sel) begin
                  ack_d = 1'b1;
                  rw_d  = rx_q[0];
                end else begin
                  st_d  = ST_IDLE;
                  cnt_d = CNT_PRE;
                end
              end
              ST_AHI: begin
                ahi_d = rx_q[HI_W-1:0];
                ack_d = 1'b1;
              end
              ST_ALO: begin
                addr_d = {ahi_q, rx_q};
                ack_d  = 1'b1;
              end
              ST_WR: begin
                ack_d  = 1'b1;
                mem_we = !(wp_q && top_hit);
                addr_d = {addr_q[ADDR_W-1:PAGE_W], addr_q[PAGE_W-1:0] + PG_ONE};
              end
              default: ;
            endcase
          end
        end else begin
          cnt_d = 4'd0;
          ack_d = 1'b0;
          unique case (st_q)
            ST_DEV: begin
              if (rw_q) begin
                st_d   = ST_RD;
                tx_d   = mem_rdata;
                addr_d = addr_q + ADDR_ONE;
              end else begin
                st_d = ST_AHI;
              end
            end
            ST_AHI: st_d = ST_ALO;
            ST_ALO: st_d = ST_WR;
            ST_RD: begin
              if (mack_q) begin
                tx_d   = mem_rdata;
                addr_d = addr_q + ADDR_ONE;
              end else begin
                st_d  = ST_IDLE;
                cnt_d = CNT_PRE;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= CNT_PRE;
      rx_q   <= '0;
      tx_q   <= '0;
      ahi_q  <= '0;
      addr_q <= '0;
      rw_q   <= 1'b0;
      ack_q  <= 1'b0;
      mack_q <= 1'b0;
      wp_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      rx_q   <= rx_d;
      tx_q   <= tx_d;
      ahi_q  <= ahi_d;
      addr_q <= addr_d;
      rw_q   <= rw_d;
      ack_q  <= ack_d;
      mack_q <= mack_d;
      wp_q   <= wp_d;
    end
  end

  assign sda_oe = ack_q | ((st_q == ST_RD) && (cnt_q < CNT_ACK) && !tx_q[7]);
endmodule

// File: rtl/i2c_ee_slave_chk.sv
module i2c_ee_slave_chk
  import i2c_ee_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PAGE_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              scl_i,
  input logic              wr_ctl,
  input logic              sda_oe,
  input ee_st_e            st,
  input logic [3:0]        bit_cnt,
  input logic              ack,
  input logic              start_det,
  input logic              mem_we,
  input logic [ADDR_W-1:0] addr
);
  logic [1:0] age;
  logic wp_win;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      age    <= 2'd0;
      wp_win <= 1'b0;
    end else begin
      if (age != 2'd3) age <= age + 2'd1;
      if (start_det) wp_win <= wr_ctl;
      else if (st == ST_DEV || st == ST_AHI || st == ST_ALO) wp_win <= wp_win | wr_ctl;
    end
  end

  // R3
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    st == ST_IDLE |-> !sda_oe);

  // R2
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack |-> bit_cnt == CNT_ACK);

  // R9
  master_ack_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RD && bit_cnt == CNT_ACK) |-> !sda_oe);

  // R4
  write_in_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> st == ST_WR);

  // R8
  page_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> addr[ADDR_W-1:PAGE_W] == $past(addr[ADDR_W-1:PAGE_W]));

  // R11
  top_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && addr[ADDR_W-1 -: 2] == 2'b11) |-> !wp_win);

  // R13
  scl_high_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3 && scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3))
      |-> $stable(sda_oe));
endmodule

bind i2c_ee_slave i2c_ee_slave_chk #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .wr_ctl(wr_ctl), .sda_oe(sda_oe),
  .st(st_q), .bit_cnt(cnt_q), .ack(ack_q), .start_det(start_det),
  .mem_we(mem_we), .addr(addr_q)
);

// File: tb/sim_i2c_ee_slave.sv
module sim_i2c_ee_slave;
  localparam int AW = 12;
  localparam int MASK = (1 << AW) - 1;
  localparam int Q = 5;
  localparam logic [2:0] STRAP = 3'b101;

  logic clk = 1'b0;
  logic rst_n, scl_m, sda_m, wr_ctl, sda_oe, sda_bus;
  int n_chk = 0, n_fail = 0, viol = 0, hi_run = 0;
  logic prev_oe = 1'b0;
  logic [7:0] ref_mem [int];
  int ref_ptr = 0;
  bit done = 0;

  always #10 clk = ~clk;
  assign sda_bus = sda_m & ~sda_oe;

  i2c_ee_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .chip_sel(STRAP), .wr_ctl(wr_ctl)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_eq(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] dsel(input bit rd);
    return {4'b1010, STRAP, rd};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic wr_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    acked = (sda_bus == 1'b0);
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic rd_byte(output logic [7:0] b, input bit mack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
      b[i] = sda_bus;
      tick(Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = mack ? 1'b0 : 1'b1; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  task automatic do_write(input int a, input logic [7:0] d[$], input bit wp_a,
                          input bit wp_d, input string req);
    bit ak;
    wr_ctl = wp_a;
    bus_start();
    wr_byte(dsel(1'b0), ak); check_eq("R2 select ack", ak, 1);
    wr_byte(8'((a >> 8) & 255), ak); check_eq("R4 addr hi ack", ak, 1);
    wr_byte(8'(a & 255), ak); check_eq("R4 addr lo ack", ak, 1);
    wr_ctl = wp_d;
    ref_ptr = a & MASK;
    foreach (d[i]) begin
      wr_byte(d[i], ak); check_eq(req, ak, 1);
      if (!(wp_a && ((ref_ptr >> (AW - 2)) == 3))) ref_mem[ref_ptr] = d[i];
      ref_ptr = (ref_ptr & ~31) | ((ref_ptr + 1) & 31);
    end
    bus_stop();
    wr_ctl = 1'b0;
    tick(Q);
  endtask

  task automatic do_read(input bit random, input int a, input int n, input string req);
    bit ak;
    logic [7:0] b;
    int exp;
    bus_start();
    if (random) begin
      wr_byte(dsel(1'b0), ak); check_eq("R6 dummy select ack", ak, 1);
      wr_byte(8'((a >> 8) & 255), ak); check_eq("R6 addr hi ack", ak, 1);
      wr_byte(8'(a & 255), ak); check_eq("R6 addr lo ack", ak, 1);
      ref_ptr = a & MASK;
      bus_start();
    end
    wr_byte(dsel(1'b1), ak); check_eq("R2 read select ack", ak, 1);
    for (int i = 0; i < n; i++) begin
      rd_byte(b, i < n - 1);
      exp = ref_mem.exists(ref_ptr) ? int'(ref_mem[ref_ptr]) : 0;
      check_eq(req, int'(b), exp);
      ref_ptr = (ref_ptr + 1) & MASK;
    end
    bus_stop();
    tick(Q);
  endtask

  // R13 monitor, sampled a quarter period after each rising edge
  always @(posedge clk) begin
    #5;
    if (rst_n === 1'b1) begin
      if (scl_m && hi_run >= 4 && sda_oe !== prev_oe) viol++;
      hi_run = scl_m ? hi_run + 1 : 0;
      prev_oe = sda_oe;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] dq[$];
    bit ak;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; wr_ctl = 1'b0;
    tick(5); rst_n = 1'b1; tick(3);
    check_eq("R1 reset release", sda_oe, 0);

    // R3: wrong device type, then traffic ignored until START
    bus_start();
    wr_byte({4'b1011, STRAP, 1'b0}, ak); check_eq("R3 bad type nack", ak, 0);
    wr_byte(8'h00, ak); check_eq("R3 ignored after mismatch", ak, 0);
    bus_stop(); tick(Q);
    // R2/R3: wrong strap
    bus_start();
    wr_byte({4'b1010, 3'b010, 1'b0}, ak); check_eq("R3 bad strap nack", ak, 0);
    bus_stop(); tick(Q);

    // R4 / R6: byte write and random read
    dq = {8'h5A}; do_write(16'h0123, dq, 0, 0, "R4 data ack");
    do_read(1, 16'h0123, 1, "R6 random read");

    // R5: upper address bits ignored
    dq = {8'h3C}; do_write(16'hE0F0, dq, 0, 0, "R5 data ack");
    do_read(1, 16'h00F0, 1, "R5 alias read");

    // R7: full page
    dq = {};
    for (int i = 0; i < 32; i++) dq.push_back(8'(i * 7 + 1));
    do_write(16'h0240, dq, 0, 0, "R7 page ack");
    do_read(1, 16'h0240, 32, "R7 R9 page readback");

    // R8: page wrap
    dq = {};
    for (int i = 0; i < 34; i++) dq.push_back(8'(8'hA0 + i));
    do_write(16'h031E, dq, 0, 0, "R8 wrap ack");
    do_read(1, 16'h0300, 32, "R8 page wrap readback");

    // R10: NACK ends read, current-address read continues
    do_read(1, 16'h0240, 2, "R10 first part");
    do_read(0, 0, 1, "R10 current address");

    // R9: array wrap
    dq = {8'h81}; do_write(16'h0FFF, dq, 0, 0, "R9 data ack");
    dq = {8'h18}; do_write(16'h0000, dq, 0, 0, "R9 data ack");
    do_read(1, 16'h0FFF, 2, "R9 array wrap");

    // R11 / R12: write control
    dq = {8'h11}; do_write(16'h0C10, dq, 0, 0, "R11 setup ack");
    dq = {8'h99}; do_write(16'h0C10, dq, 1, 1, "R11 protected ack");
    do_read(1, 16'h0C10, 1, "R11 top quarter unchanged");
    dq = {8'h77}; do_write(16'h0410, dq, 1, 1, "R11 low ack");
    do_read(1, 16'h0410, 1, "R11 lower quarter written");
    dq = {8'h55}; do_write(16'h0C20, dq, 0, 1, "R12 ack");
    do_read(1, 16'h0C20, 1, "R12 late control ignored");

    check_eq("R13 sda_oe steady while SCL high", viol, 0);
    check_eq("R1 idle release", sda_oe, 0);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule